// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This combinational block sits beside a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It looks at the source register numbers of the instruction in execute and the instruction in decode. It also looks at the destination numbers and write enables of the instructions in the memory and writeback stages, and at whether the instruction in execute is a load. From these it picks where each ALU operand comes from and where the store data of the instruction in memory comes from. It also decides whether the pipeline must hold for one cycle.

An ALU result is bypassed straight to a dependent instruction, so no cycle is lost. The only dependence that costs time is a load whose destination is read by the very next instruction. In that case the fetch address and the decode register hold, and the execute stage receives a bubble. A load whose value is only stored by the next instruction costs nothing. The stored value is picked up from writeback while the store is in the memory stage. Because every instruction reads registers in decode and writes them in writeback, write-after-read and write-after-write orderings cannot go wrong, and the block does not look for them. The operand and store-data multiplexers are part of the block, so the selected data can be observed directly.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes (`mem_we`=1) a nonzero register equal to an execute source, that operand's select is 2'b10 and the operand equals `mem_alu`.
- R2: When only the writeback-stage instruction writes (`wb_we`=1) a nonzero register equal to an execute source, that operand's select is 2'b01 and the operand equals `wb_data`.
- R3: When both later stages match the same source, the memory-stage value (2'b10) wins over the writeback value.
- R4: A destination of register 0 is never bypassed, so the select stays 2'b00 and the operand is the register-file value.
- R5: A matching destination whose write enable is 0 is not bypassed.
- R6: With no match, the select is 2'b00 and the operand equals the register-file read (`rf_a` or `rf_b`). The select never takes the value 2'b11.
- R7: When `ex_is_load`=1 and `ex_rd` is nonzero and equals `id_rs1`, or equals `id_rs2` of a non-store, then `pc_hold`, `ifid_hold` and `idex_flush` are all 1.
- R8: A decode-stage store (`id_is_store`=1) whose data register `id_rs2` matches the load in execute does not stall. A store whose base `id_rs1` matches does stall.
- R9: No stall is raised when the execute instruction is not a load, or when the load targets register 0.
- R10: When writeback writes a nonzero register equal to `mem_src2`, `st_sel`=1 and `store_data` equals `wb_data`. Otherwise `st_sel`=0 and `store_data` equals `mem_store_in`.
- R11: `pc_hold`, `ifid_hold` and `idex_flush` always carry the same value, so that a single bubble is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | RW | First source register of the instruction in execute |
| ex_rs2 | input | RW | Second source register of the instruction in execute |
| ex_rd | input | RW | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| id_rs1 | input | RW | First source register of the instruction in decode |
| id_rs2 | input | RW | Second source register of the instruction in decode |
| id_is_store | input | 1 | Instruction in decode is a store (rs2 is data only) |
| mem_rd | input | RW | Destination register in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_src2 | input | RW | Store data register of the memory-stage instruction |
| wb_rd | input | RW | Destination register in the writeback stage |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| rf_a | input | XLEN | Register-file value for the first operand |
| rf_b | input | XLEN | Register-file value for the second operand |
| mem_alu | input | XLEN | ALU result held in the memory stage |
| wb_data | input | XLEN | Value being written back |
| mem_store_in | input | XLEN | Store data carried into the memory stage |
| fwd_a_sel | output | 2 | First operand source: 00 file, 01 writeback, 10 memory |
| fwd_b_sel | output | 2 | Second operand source, same coding |
| st_sel | output | 1 | Store data taken from writeback |
| opnd_a | output | XLEN | Selected first ALU operand |
| opnd_b | output | XLEN | Selected second ALU operand |
| store_data | output | XLEN | Selected store data |
| pc_hold | output | 1 | Keep the fetch address this cycle |
| ifid_hold | output | 1 | Keep the decode register this cycle |
| idex_flush | output | 1 | Clear the execute register and its write enables |

## Verification
The bench sets up dependences where both later stages name the same register. A design with the priority reversed would hand over the older writeback value. It drives register 0 as a destination with the write enable high. A design without the zero guard would bypass a stale value into an operand that must read zero. It places a store behind a load on the data register and on the base register. This catches a design that stalls on every load match, and one that never stalls for a store. It also checks that the three hold and flush outputs rise together, because a design that held fetch but did not clear execute would issue the load's consumer twice.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic [RW-1:0]   ex_rs1,
  input  logic [RW-1:0]   ex_rs2,
  input  logic [RW-1:0]   ex_rd,
  input  logic            ex_is_load,
  input  logic [RW-1:0]   id_rs1,
  input  logic [RW-1:0]   id_rs2,
  input  logic            id_is_store,
  input  logic [RW-1:0]   mem_rd,
  input  logic            mem_we,
  input  logic [RW-1:0]   mem_src2,
  input  logic [RW-1:0]   wb_rd,
  input  logic            wb_we,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  input  logic [XLEN-1:0] mem_alu,
  input  logic [XLEN-1:0] wb_data,
  input  logic [XLEN-1:0] mem_store_in,
  output logic [1:0]      fwd_a_sel,
  output logic [1:0]      fwd_b_sel,
  output logic            st_sel,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] store_data,
  output logic            pc_hold,
  output logic            ifid_hold,
  output logic            idex_flush
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic mem_ok, wb_ok, ld_hit, stall;

  assign mem_ok = mem_we && (mem_rd != '0);
  assign wb_ok  = wb_we  && (wb_rd  != '0);

  assign fwd_a_sel = (mem_ok && mem_rd == ex_rs1) ? SEL_MEM :
                     (wb_ok  && wb_rd  == ex_rs1) ? SEL_WB  : SEL_RF;
  assign fwd_b_sel = (mem_ok && mem_rd == ex_rs2) ? SEL_MEM :
                     (wb_ok  && wb_rd  == ex_rs2) ? SEL_WB  : SEL_RF;

  always_comb begin
    case (fwd_a_sel)
      SEL_MEM: opnd_a = mem_alu;
      SEL_WB:  opnd_a = wb_data;
      default: opnd_a = rf_a;
    endcase
    case (fwd_b_sel)
      SEL_MEM: opnd_b = mem_alu;
      SEL_WB:  opnd_b = wb_data;
      default: opnd_b = rf_b;
    endcase
  end

  assign st_sel     = wb_ok && (wb_rd == mem_src2);
  assign store_data = st_sel ? wb_data : mem_store_in;

  assign ld_hit = (ex_rd == id_rs1) || ((ex_rd == id_rs2) && !id_is_store);
  assign stall  = ex_is_load && (ex_rd != '0) && ld_hit;

  assign pc_hold    = stall;
  assign ifid_hold  = stall;
  assign idex_flush = stall;

endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input logic [RW-1:0]   ex_rs1,
  input logic [RW-1:0]   ex_rs2,
  input logic [RW-1:0]   ex_rd,
  input logic            ex_is_load,
  input logic [RW-1:0]   mem_rd,
  input logic            mem_we,
  input logic            wb_we,
  input logic [XLEN-1:0] rf_a,
  input logic [XLEN-1:0] mem_alu,
  input logic [XLEN-1:0] wb_data,
  input logic [1:0]      fwd_a_sel,
  input logic [1:0]      fwd_b_sel,
  input logic            st_sel,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] store_data,
  input logic            pc_hold,
  input logic            ifid_hold,
  input logic            idex_flush
);

  always_comb begin
    AST_SEL_LEGAL: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11); // R6
    if (fwd_a_sel == 2'b10)
      AST_MEM_DATA: assert (opnd_a == mem_alu && mem_we); // R1
    if (fwd_a_sel == 2'b01)
      AST_WB_DATA: assert (opnd_a == wb_data && wb_we); // R2
    if (mem_we && mem_rd != '0 && mem_rd == ex_rs1)
      AST_MEM_FIRST: assert (fwd_a_sel == 2'b10); // R3
    if (ex_rs1 == '0)
      AST_ZERO_SRC: assert (fwd_a_sel == 2'b00 && opnd_a == rf_a); // R4
    if (pc_hold)
      AST_STALL_LOAD: assert (ex_is_load && ex_rd != '0); // R9
    AST_HOLD_TIED: assert (pc_hold == ifid_hold && ifid_hold == idex_flush); // R11
    if (st_sel)
      AST_ST_WB: assert (wb_we && store_data == wb_data); // R10
  end

endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.XLEN(XLEN), .NREG(NREG)) chk_i (
  .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_is_load(ex_is_load),
  .mem_rd(mem_rd), .mem_we(mem_we), .wb_we(wb_we), .rf_a(rf_a),
  .mem_alu(mem_alu), .wb_data(wb_data), .fwd_a_sel(fwd_a_sel),
  .fwd_b_sel(fwd_b_sel), .st_sel(st_sel), .opnd_a(opnd_a),
  .store_data(store_data), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
  .idex_flush(idex_flush)
);

// File: tb/hazard_fwd_unit_tb_top.sv
module hazard_fwd_unit_tb_top;
  localparam int XLEN = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [RW-1:0] ex_rs1, ex_rs2, ex_rd, id_rs1, id_rs2, mem_rd, mem_src2, wb_rd;
  logic ex_is_load, id_is_store, mem_we, wb_we;
  logic [XLEN-1:0] rf_a, rf_b, mem_alu, wb_data, mem_store_in;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic st_sel, pc_hold, ifid_hold, idex_flush;
  logic [XLEN-1:0] opnd_a, opnd_b, store_data;

  int n_chk = 0;
  int n_bad = 0;

  hazard_fwd_unit #(.XLEN(XLEN), .NREG(32)) dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; id_rs1 = '0; id_rs2 = '0;
    mem_rd = '0; mem_src2 = '0; wb_rd = '0;
    ex_is_load = 0; id_is_store = 0; mem_we = 0; wb_we = 0;
    rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002; mem_alu = 32'hC0DE_0003;
    wb_data = 32'hD0D0_0004; mem_store_in = 32'hE0E0_0005;
  endtask

  task automatic settle(); #1; endtask

  task automatic t_reset();
    idle(); settle();
    check("R6 rst sel_a", fwd_a_sel, 2'b00);
    check("R6 rst opnd_b", opnd_b, 32'hB0B0_0002);
    check("R9 rst stall", pc_hold, 0);
  endtask

  task automatic t_exmem();
    idle(); ex_rs1 = 3; ex_rs2 = 6; mem_rd = 3; mem_we = 1; settle();
    check("R1 sel_a", fwd_a_sel, 2'b10);
    check("R1 opnd_a", opnd_a, 32'hC0DE_0003);
    check("R6 sel_b", fwd_b_sel, 2'b00);
  endtask

  task automatic t_memwb();
    idle(); ex_rs2 = 5; wb_rd = 5; wb_we = 1; settle();
    check("R2 sel_b", fwd_b_sel, 2'b01);
    check("R2 opnd_b", opnd_b, 32'hD0D0_0004);
  endtask

  task automatic t_priority();
    idle(); ex_rs1 = 7; ex_rs2 = 7; mem_rd = 7; wb_rd = 7; mem_we = 1; wb_we = 1; settle();
    check("R3 sel_a", fwd_a_sel, 2'b10);
    check("R3 opnd_b", opnd_b, 32'hC0DE_0003);
  endtask

  task automatic t_zero();
    idle(); mem_we = 1; wb_we = 1; settle();
    check("R4 sel_a", fwd_a_sel, 2'b00);
    check("R4 opnd_a", opnd_a, 32'hA0A0_0001);
    check("R4 opnd_b", opnd_b, 32'hB0B0_0002);
  endtask

  task automatic t_we_low();
    idle(); ex_rs1 = 9; mem_rd = 9; wb_rd = 9; settle();
    check("R5 sel_a", fwd_a_sel, 2'b00);
    check("R5 opnd_a", opnd_a, 32'hA0A0_0001);
  endtask

  task automatic t_load_use();
    idle(); ex_is_load = 1; ex_rd = 4; id_rs2 = 4; id_rs1 = 1; settle();
    check("R7 pc_hold rs2", pc_hold, 1);
    check("R7 ifid_hold", ifid_hold, 1);
    check("R7 idex_flush", idex_flush, 1);
    idle(); ex_is_load = 1; ex_rd = 4; id_rs1 = 4; settle();
    check("R7 pc_hold rs1", pc_hold, 1);
  endtask

  task automatic t_load_store();
    idle(); ex_is_load = 1; ex_rd = 4; id_rs2 = 4; id_rs1 = 1; id_is_store = 1; settle();
    check("R8 store data no stall", pc_hold, 0);
    check("R11 flush low", idex_flush, 0);
    idle(); ex_is_load = 1; ex_rd = 4; id_rs1 = 4; id_is_store = 1; settle();
    check("R8 store base stall", idex_flush, 1);
  endtask

  task automatic t_no_load();
    idle(); ex_rd = 4; id_rs1 = 4; settle();
    check("R9 not load", pc_hold, 0);
    idle(); ex_is_load = 1; settle();
    check("R9 load r0", ifid_hold, 0);
  endtask

  task automatic t_store_fwd();
    idle(); mem_src2 = 4; wb_rd = 4; wb_we = 1; settle();
    check("R10 st_sel", st_sel, 1);
    check("R10 store_data wb", store_data, 32'hD0D0_0004);
    idle(); wb_we = 1; settle();
    check("R10 r0 st_sel", st_sel, 0);
    check("R10 store_data pass", store_data, 32'hE0E0_0005);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_exmem(); t_memwb(); t_priority(); t_zero(); t_we_low();
        t_load_use(); t_load_store(); t_no_load(); t_store_fwd();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule